// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the register file that a host CPU uses to reach a tile-based video processor. The CPU selects one of eight registers with a 3-bit index and uses separate read and write strobes on an 8-bit bus. The block keeps a control byte and a mask byte, and it reports a vertical-blank flag through a status read. It takes scroll values through a port that needs two writes. Video-memory addresses are set through a second two-write port. A data port moves bytes to and from an external video-memory bus and steps the address after each access.

The scroll port and the address port share one first/second-write toggle, and both work on a 15-bit temporary address. The second write to the address port copies that temporary value into the active scan address, which is the address the renderer later uses. Writes to control, scroll and address therefore all move the address that rendering starts from. A pulse from the timing generator sets the vertical-blank flag, and a second pulse clears it. An interrupt request is raised while the flag is set and interrupts are enabled.

Top module: `vdp_cpu_regs`

## Requirements
- R1: After reset, ctrl_out, mask_out, rdata, fine_x, tmp_addr, scan_addr and vm_addr are all zero, nmi is low, vm_wr and vm_rd are low, and the shared toggle expects a first write.
- R2: A write to index 0 stores the byte on ctrl_out, and a write to index 1 stores it on mask_out. Control fields: bits 1:0 name table, bit 2 step size (0 gives 1, 1 gives STEP_WIDE), bit 3 sprite pattern base, bit 4 background pattern base, bit 5 sprite size, bit 7 interrupt enable. Mask fields: bit 0 grey, bits 2:1 left-edge show, bits 4:3 show background and sprites, bits 7:5 emphasis.
- R3: A read of index 2 returns the vertical-blank flag in bit 7, with bits 6:0 zero, and clears the flag on the following cycle. vbl_start sets the flag and vbl_end clears it. When vbl_start and a status read fall in the same cycle, the flag stays set.
- R4: Index 6 takes two writes. The first places data bits 5:0 into tmp_addr[13:8] and clears tmp_addr[14]. The second places the whole byte into tmp_addr[7:0] and copies tmp_addr into scan_addr. A first write leaves scan_addr unchanged.
- R5: A write to index 7 drives vm_wr high for that cycle, with vm_wdata equal to the byte and vm_addr equal to the current address. On the next cycle scan_addr advances by 1, or by STEP_WIDE when control bit 2 is set, and wraps at 15 bits. vm_addr is scan_addr[13:0].
- R6: A read of index 7 drives vm_rd high for that cycle at the current address and then advances the address as in R5. vm_rdata is captured one cycle after vm_rd. The byte returned by a data read is the one captured from the previous data read, and it reads zero after reset. A write takes priority over a read in the same cycle.
- R7: Index 5 takes two writes. The first sets fine_x to data[2:0] and tmp_addr[4:0] to data[7:3]. The second sets tmp_addr[14:12] to data[2:0] and tmp_addr[9:5] to data[7:3]. Neither write changes scan_addr.
- R8: Indices 5 and 6 share one toggle, so a first write to one port followed by a write to the other acts as the second write. A status read returns the toggle to the first-write state.
- R9: A write to index 0 copies data[1:0] into tmp_addr[11:10] and leaves the other tmp_addr bits unchanged.
- R10: nmi is high exactly when control bit 7 and the vertical-blank flag are both set. Setting bit 7 while the flag is already set raises nmi on the next cycle.
- R11: Writes to indices 2, 3 and 4 change no state. Reads of indices other than 2 and 7 return 0x00 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 3 | Register index |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Registered CPU read data |
| vbl_start | input | 1 | Pulse that sets the vertical-blank flag |
| vbl_end | input | 1 | Pulse that clears the vertical-blank flag |
| nmi | output | 1 | Interrupt request |
| ctrl_out | output | 8 | Control byte |
| mask_out | output | 8 | Mask byte |
| fine_x | output | 3 | Fine horizontal scroll |
| tmp_addr | output | 15 | Temporary address for the renderer |
| scan_addr | output | 15 | Active scan address |
| vm_addr | output | 14 | Video-memory request address |
| vm_wr | output | 1 | Video-memory write request |
| vm_rd | output | 1 | Video-memory read request |
| vm_wdata | output | 8 | Video-memory write data |
| vm_rdata | input | 8 | Video-memory read data, valid the cycle after vm_rd |

## Verification
The bench builds the block with its default STEP_WIDE of 32, so both step sizes are exercised. With that value, a data write at 0x3FF0 carries the 15-bit scan address into bit 14, which makes the wrap of vm_addr back to 0x0010 visible. Directed sequences interleave scroll, address and control writes, and they reset the toggle with status reads. This lets every field that lands in tmp_addr be checked against hand-computed values.

// File: rtl/vdp_regs_pkg.sv
package vdp_regs_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 3;
  localparam int VA_W  = 15;
  localparam int VM_AW = VA_W - 1;
  localparam int FX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    RS_CTRL   = 3'd0,
    RS_MASK   = 3'd1,
    RS_STAT   = 3'd2,
    RS_RSV3   = 3'd3,
    RS_RSV4   = 3'd4,
    RS_SCROLL = 3'd5,
    RS_ADDR   = 3'd6,
    RS_DATA   = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic ctrl;
    logic mask;
    logic scroll;
    logic addr;
    logic data;
  } wr_strobe_t;
endpackage

// File: rtl/vdp_addr_unit.sv
module vdp_addr_unit
  import vdp_regs_pkg::*;
#(
  parameter int STEP_WIDE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       stb,
  input  logic             step,
  input  logic             step_wide,
  input  logic             toggle_clr,
  input  logic [DW-1:0]    wdata,
  output logic [VA_W-1:0]  scan_addr,
  output logic [VA_W-1:0]  tmp_addr,
  output logic [FX_W-1:0]  fine_x,
  output logic             second
);
  localparam logic [VA_W-1:0] STEP_W = VA_W'(STEP_WIDE);
  localparam logic [VA_W-1:0] STEP_N = VA_W'(1);

  logic [VA_W-1:0] v_q, v_d, t_q, t_d;
  logic [FX_W-1:0] fx_q, fx_d;
  logic            sec_q, sec_d;
  logic            en;

  assign en = stb.ctrl | stb.scroll | stb.addr | step | toggle_clr;

  always_comb begin
    v_d   = v_q;
    t_d   = t_q;
    fx_d  = fx_q;
    sec_d = sec_q;
    if (stb.ctrl) begin
      t_d[11:10] = wdata[1:0];
    end
    if (stb.scroll) begin
      if (!sec_q) begin
        t_d[4:0] = wdata[7:3];
        fx_d     = wdata[2:0];
        sec_d    = 1'b1;
      end else begin
        t_d[14:12] = wdata[2:0];
        t_d[9:5]   = wdata[7:3];
        sec_d      = 1'b0;
      end
    end
    if (stb.addr) begin
      if (!sec_q) begin
        t_d[13:8] = wdata[5:0];
        t_d[14]   = 1'b0;
        sec_d     = 1'b1;
      end else begin
        t_d[7:0] = wdata;
        v_d      = t_d;
        sec_d    = 1'b0;
      end
    end
    if (step) begin
      v_d = v_q + (step_wide ? STEP_W : STEP_N);
    end
    if (toggle_clr) begin
      sec_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      t_q   <= '0;
      fx_q  <= '0;
      sec_q <= 1'b0;
    end else if (en) begin
      v_q   <= v_d;
      t_q   <= t_d;
      fx_q  <= fx_d;
      sec_q <= sec_d;
    end
  end

  assign scan_addr = v_q;
  assign tmp_addr  = t_q;
  assign fine_x    = fx_q;
  assign second    = sec_q;
endmodule

// File: rtl/vdp_vblank_unit.sv
module vdp_vblank_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic vbl_start,
  input  logic vbl_end,
  input  logic status_rd,
  input  logic nmi_en,
  output logic vbl_flag,
  output logic nmi
);
  logic vbl_q, vbl_d, en;

  assign en = vbl_start | vbl_end | status_rd;

  always_comb begin
    vbl_d = vbl_q;
    if (vbl_start) begin
      vbl_d = 1'b1;
    end else if (vbl_end || status_rd) begin
      vbl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbl_q <= 1'b0;
    end else if (en) begin
      vbl_q <= vbl_d;
    end
  end

  assign vbl_flag = vbl_q;
  assign nmi      = vbl_q & nmi_en;
endmodule

// File: rtl/vdp_data_port.sv
module vdp_data_port
  import vdp_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [VM_AW-1:0] addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    vm_rdata,
  output logic [VM_AW-1:0] vm_addr,
  output logic             vm_wr,
  output logic             vm_rd,
  output logic [DW-1:0]    vm_wdata,
  output logic [DW-1:0]    rbuf
);
  logic          pend_q, pend_d;
  logic [DW-1:0] buf_q, buf_d;

  assign vm_addr  = addr;
  assign vm_wr    = wr_req;
  assign vm_rd    = rd_req;
  assign vm_wdata = wdata;

  always_comb begin
    pend_d = rd_req;
    buf_d  = pend_q ? vm_rdata : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (pend_q) begin
        buf_q <= buf_d;
      end
    end
  end

  assign rbuf = buf_q;
endmodule

// File: rtl/vdp_cpu_regs.sv
module vdp_cpu_regs
  import vdp_regs_pkg::*;
#(
  parameter int STEP_WIDE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             vbl_start,
  input  logic             vbl_end,
  output logic             nmi,
  output logic [DW-1:0]    ctrl_out,
  output logic [DW-1:0]    mask_out,
  output logic [FX_W-1:0]  fine_x,
  output logic [VA_W-1:0]  tmp_addr,
  output logic [VA_W-1:0]  scan_addr,
  output logic [VM_AW-1:0] vm_addr,
  output logic             vm_wr,
  output logic             vm_rd,
  output logic [DW-1:0]    vm_wdata,
  input  logic [DW-1:0]    vm_rdata
);
  wr_strobe_t    stb;
  logic          rd_ok, rd_stat, rd_data;
  logic          vbl_flag, wt_second;
  logic [DW-1:0] ctrl_q, mask_q, rdata_q, rd_val, rbuf;

  // Decode: a write wins over a read in the same cycle.
  assign stb.ctrl   = wr_en && (reg_idx == RS_CTRL);
  assign stb.mask   = wr_en && (reg_idx == RS_MASK);
  assign stb.scroll = wr_en && (reg_idx == RS_SCROLL);
  assign stb.addr   = wr_en && (reg_idx == RS_ADDR);
  assign stb.data   = wr_en && (reg_idx == RS_DATA);
  assign rd_ok      = rd_en && !wr_en;
  assign rd_stat    = rd_ok && (reg_idx == RS_STAT);
  assign rd_data    = rd_ok && (reg_idx == RS_DATA);

  always_comb begin
    case (reg_idx)
      RS_STAT: rd_val = {vbl_flag, {(DW-1){1'b0}}};
      RS_DATA: rd_val = rbuf;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (stb.ctrl) ctrl_q  <= wdata;
      if (stb.mask) mask_q  <= wdata;
      if (rd_ok)    rdata_q <= rd_val;
    end
  end

  assign ctrl_out = ctrl_q;
  assign mask_out = mask_q;
  assign rdata    = rdata_q;

  vdp_addr_unit #(.STEP_WIDE(STEP_WIDE)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .step       (stb.data | rd_data),
    .step_wide  (ctrl_q[2]),
    .toggle_clr (rd_stat),
    .wdata      (wdata),
    .scan_addr  (scan_addr),
    .tmp_addr   (tmp_addr),
    .fine_x     (fine_x),
    .second     (wt_second)
  );

  vdp_vblank_unit u_vbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vbl_start (vbl_start),
    .vbl_end   (vbl_end),
    .status_rd (rd_stat),
    .nmi_en    (ctrl_q[7]),
    .vbl_flag  (vbl_flag),
    .nmi       (nmi)
  );

  vdp_data_port u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (stb.data),
    .rd_req   (rd_data),
    .addr     (scan_addr[VM_AW-1:0]),
    .wdata    (wdata),
    .vm_rdata (vm_rdata),
    .vm_addr  (vm_addr),
    .vm_wr    (vm_wr),
    .vm_rd    (vm_rd),
    .vm_wdata (vm_wdata),
    .rbuf     (rbuf)
  );
endmodule

// File: rtl/vdp_cpu_regs_chk.sv
module vdp_cpu_regs_chk
  import vdp_regs_pkg::*;
#(
  parameter int STEP_WIDE = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] reg_idx,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    wdata,
  input logic             vbl_start,
  input logic             nmi,
  input logic [DW-1:0]    ctrl_out,
  input logic [VM_AW-1:0] vm_addr,
  input logic             vm_wr,
  input logic             vm_rd,
  input logic             vbl_flag,
  input logic             wt_second,
  input logic [5:0]       tmp_hi
);
  localparam logic [VM_AW-1:0] STEP_W = VM_AW'(STEP_WIDE);
  localparam logic [VM_AW-1:0] STEP_N = VM_AW'(1);

  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_start |=> vbl_flag);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_idx == 3'd2 && !vbl_start) |=> !vbl_flag);

  a_r4_copy_on_second: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 3'd6 && wt_second) |=> (vm_addr == {$past(tmp_hi), $past(wdata)}));

  a_r5_data_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 3'd7) |=>
      (vm_addr == VM_AW'($past(vm_addr) + ($past(ctrl_out[2]) ? STEP_W : STEP_N))));

  a_r6_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vm_wr, vm_rd}));

  a_r8_status_resets_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_idx == 3'd2) |=> !wt_second);

  a_r10_nmi_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && ctrl_out[7] && !(wr_en && reg_idx == 3'd0)) |=> nmi);

  a_r10_nmi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_out[7] |-> !nmi);
endmodule

bind vdp_cpu_regs vdp_cpu_regs_chk #(.STEP_WIDE(STEP_WIDE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_idx   (reg_idx),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .vbl_start (vbl_start),
  .nmi       (nmi),
  .ctrl_out  (ctrl_out),
  .vm_addr   (vm_addr),
  .vm_wr     (vm_wr),
  .vm_rd     (vm_rd),
  .vbl_flag  (vbl_flag),
  .wt_second (wt_second),
  .tmp_hi    (tmp_addr[13:8])
);

// File: tb/sim_vdp_cpu_regs.sv
`timescale 1ns/1ps
module sim_vdp_cpu_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        vbl_start = 1'b0, vbl_end = 1'b0;
  logic        nmi;
  logic [7:0]  ctrl_out, mask_out;
  logic [2:0]  fine_x;
  logic [14:0] tmp_addr, scan_addr;
  logic [13:0] vm_addr;
  logic        vm_wr, vm_rd;
  logic [7:0]  vm_wdata;
  logic [7:0]  vm_rdata = '0;

  int n_chk = 0, n_bad = 0;
  logic        cap_wr, cap_rd;
  logic [13:0] cap_addr;
  logic [7:0]  cap_wdata;

  always #2.5 clk = ~clk;

  vdp_cpu_regs u0 (.*);

  function automatic logic [7:0] mem_f(input logic [13:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (vm_rd) vm_rdata <= mem_f(vm_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; wdata = d; wr_en = 1'b1;
    #1;
    cap_wr = vm_wr; cap_addr = vm_addr; cap_wdata = vm_wdata; cap_rd = vm_rd;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] idx);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    #1;
    cap_rd = vm_rd; cap_addr = vm_addr; cap_wr = vm_wr;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic e);
    @(negedge clk);
    vbl_start = s; vbl_end = e;
    @(negedge clk);
    vbl_start = 1'b0; vbl_end = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    do_rd(3'd2);
    do_wr(3'd6, hi);
    do_wr(3'd6, lo);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_out, 0);
    chk("R1 mask", mask_out, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 nmi", nmi, 0);
    chk("R1 scan", scan_addr, 0);
    chk("R1 tmp", tmp_addr, 0);
    chk("R1 fine_x", fine_x, 0);
    chk("R1 req", {vm_wr, vm_rd}, 0);
  endtask

  task automatic t_ctrl_mask;
    do_wr(3'd0, 8'h18);
    chk("R2 ctrl", ctrl_out, 8'h18);
    do_wr(3'd1, 8'h1E);
    chk("R2 mask", mask_out, 8'h1E);
    chk("R9 nt zero keeps tmp", tmp_addr, 0);
  endtask

  task automatic t_addr;
    do_rd(3'd2);
    do_wr(3'd6, 8'h3F);
    chk("R4 first write no copy", scan_addr, 0);
    do_wr(3'd6, 8'h00);
    chk("R4 addr 3F00", vm_addr, 14'h3F00);
    set_addr(8'hFF, 8'h80);
    chk("R4 high bits masked", scan_addr, 15'h3F80);
    chk("R4 tmp", tmp_addr, 15'h3F80);
  endtask

  task automatic t_data_write;
    do_wr(3'd0, 8'h00);
    set_addr(8'h3F, 8'h00);
    do_wr(3'd7, 8'hAB);
    chk("R5 vm_wr", cap_wr, 1);
    chk("R5 vm_addr at write", cap_addr, 14'h3F00);
    chk("R5 vm_wdata", cap_wdata, 8'hAB);
    chk("R5 step 1", vm_addr, 14'h3F01);
    do_wr(3'd0, 8'h04);
    do_wr(3'd7, 8'h55);
    chk("R5 addr second", cap_addr, 14'h3F01);
    chk("R5 step 32", vm_addr, 14'h3F21);
    set_addr(8'h3F, 8'hF0);
    do_wr(3'd7, 8'h01);
    chk("R5 wrap scan", scan_addr, 15'h4010);
    chk("R5 wrap vm_addr", vm_addr, 14'h0010);
    do_wr(3'd0, 8'h00);
  endtask

  task automatic t_data_read;
    set_addr(8'h21, 8'h05);
    do_rd(3'd7);
    chk("R6 vm_rd", cap_rd, 1);
    chk("R6 rd addr", cap_addr, 14'h2105);
    chk("R6 first read is old buffer", rdata, 8'h00);
    chk("R6 step", vm_addr, 14'h2106);
    do_rd(3'd7);
    chk("R6 buffered byte", rdata, mem_f(14'h2105));
    chk("R6 step again", vm_addr, 14'h2107);
  endtask

  task automatic t_scroll;
    do_rd(3'd2);
    do_wr(3'd5, 8'h7D);
    chk("R7 fine_x", fine_x, 3'd5);
    chk("R7 coarse x", tmp_addr, 15'h210F);
    do_wr(3'd5, 8'h5E);
    chk("R7 y fields", tmp_addr, 15'h616F);
    chk("R7 scan unchanged", vm_addr, 14'h2107);
  endtask

  task automatic t_nametable;
    do_wr(3'd0, 8'h03);
    chk("R9 nt 3", tmp_addr, 15'h6D6F);
    do_wr(3'd0, 8'h01);
    chk("R9 nt 1", tmp_addr, 15'h656F);
  endtask

  task automatic t_toggle;
    do_rd(3'd2);
    do_wr(3'd5, 8'h00);
    do_wr(3'd6, 8'h12);
    chk("R8 shared toggle copy", vm_addr, 14'h2512);
    do_wr(3'd6, 8'h11);
    do_rd(3'd2);
    do_wr(3'd6, 8'h11);
    chk("R8 status reset toggle", vm_addr, 14'h2512);
    do_wr(3'd6, 8'h22);
    chk("R8 pair after reset", vm_addr, 14'h1122);
  endtask

  task automatic t_ignore;
    do_wr(3'd3, 8'h77);
    chk("R11 idx3 no req", cap_wr, 0);
    do_wr(3'd4, 8'h99);
    do_wr(3'd2, 8'hFF);
    chk("R11 ctrl kept", ctrl_out, 8'h01);
    chk("R11 mask kept", mask_out, 8'h1E);
    chk("R11 tmp kept", tmp_addr, 15'h1122);
    chk("R11 scan kept", vm_addr, 14'h1122);
    do_rd(3'd0);
    chk("R11 read idx0", rdata, 8'h00);
    do_wr(3'd6, 8'h01);
    do_wr(3'd6, 8'h02);
    chk("R11 toggle untouched", vm_addr, 14'h0102);
  endtask

  task automatic t_vblank;
    do_wr(3'd0, 8'h80);
    chk("R10 no flag no nmi", nmi, 0);
    pulse(1'b1, 1'b0);
    chk("R10 nmi on start", nmi, 1);
    do_rd(3'd2);
    chk("R3 status bit7", rdata, 8'h80);
    chk("R10 nmi drops after read", nmi, 0);
    do_rd(3'd2);
    chk("R3 flag cleared", rdata, 8'h00);
    do_wr(3'd0, 8'h00);
    pulse(1'b1, 1'b0);
    chk("R10 disabled", nmi, 0);
    do_wr(3'd0, 8'h80);
    chk("R10 late enable", nmi, 1);
    pulse(1'b0, 1'b1);
    chk("R3 end clears", nmi, 0);
    @(negedge clk);
    reg_idx = 3'd2; rd_en = 1'b1; vbl_start = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; vbl_start = 1'b0;
    chk("R3 read pre-value", rdata, 8'h00);
    chk("R3 start wins", nmi, 1);
    do_rd(3'd2);
    chk("R3 flag seen", rdata, 8'h80);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_addr();
    t_data_write();
    t_data_read();
    t_scroll();
    t_nametable();
    t_toggle();
    t_ignore();
    t_vblank();
    summary();
  end
endmodule